// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a synchronous host to an external asynchronous static RAM that holds 128K bytes. The host raises a request with a read/write flag, a 17-bit address and an 8-bit write value. The controller sequences the RAM control pins: an active-low chip enable, an active-high chip enable, an active-low write enable and an active-low output enable. It returns read data together with a one-cycle done pulse. The data bus is presented as a split output value, an output-enable and an input value, so the tri-state pad can live in the pad ring.

The RAM's timing limits are given in nanoseconds and depend on the speed grade. The controller turns each limit into a whole number of clock cycles: ceil(delay / period), computed from parameters. The limits are the read cycle time, the address access time, the output-enable-to-data time and the two bus-release times. While idle, the RAM is kept deselected, which puts it in its low-power standby. After a read, the RAM may keep driving the bus for a while. A write that follows a read is therefore held back until that window has passed.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever idle, the RAM is parked: `ram_ce_n`=1, `ram_ce`=0, `ram_we_n`=1, `ram_oe_n`=1, `dq_oe`=0, `ready`=1, `done`=0.
- R2: A request is accepted only on a rising clock edge where both `req` and `ready` are high. Address, flag and write value are sampled on that edge. Later changes on the request inputs have no effect until the next acceptance, and each acceptance produces exactly one done pulse.
- R3: A read keeps the RAM selected with `ram_oe_n`=0, `ram_we_n`=1 and `dq_oe`=0 for RD cycles, starting with the cycle after the accepting edge. RD is the largest of ceil(tRC/T), ceil(tAA/T) and ceil(tOE/T): 6 for the fast grade at a 10 ns clock, 7 for the slow grade.
- R4: The byte on `dq_in` during the last read cycle is registered into `rdata`. In the next cycle `done` is high for exactly one cycle, with `ready`=1 and the RAM parked.
- R5: A write runs as follows. First, one setup cycle with the RAM selected, `ram_we_n`=1 and `dq_oe`=1. Then WE cycles (parameter, default 3) with `ram_we_n`=0. Then one hold cycle with `ram_we_n`=1 and `dq_oe` still 1. Throughout, `ram_oe_n`=1 and `dq_out` equals the sampled write value.
- R6: TURN is the larger of ceil(tOHZ/T) and ceil(tCHZ/T), which is 4 at defaults. `dq_oe` stays 0 for TURN cycles after the last cycle in which a read had the RAM output enabled. A write accepted inside that window waits parked, with `ready`=0, and starts its setup cycle as soon as the window ends.
- R7: After the hold cycle of a write, the RAM is parked, `ready`=1 and `done` pulses for one cycle. A new request may be accepted on the edge that ends a done cycle.
- R8: `ram_addr` carries the sampled address from the edge on which the chip enables become active, and stays stable in every selected cycle of that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write value |
| ready | output | 1 | Controller can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read result |
| ram_addr | output | 17 | RAM address pins |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_ce | output | 1 | RAM chip enable, active high |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| dq_out | output | 8 | Value driven onto the data bus |
| dq_oe | output | 1 | Drive enable for the data bus pads |
| dq_in | input | 8 | Value sampled from the data bus |

## Verification
The hardest situation to reach is a write accepted while the RAM may still be releasing the bus after a read. Reaching it needs a read followed immediately by a write, with the write request already waiting when `ready` returns. The bench produces this both with a back-to-back read-then-write call and with a long stretch in which `req` stays high while the address, value and read/write flag change every cycle. This gives turnaround waits of every length the timing allows. The bench's memory model returns the complement of the stored byte until the last read cycle, so a capture taken one cycle too early is caught. The model also records the last cycle in which the RAM drove the bus, and flags any controller drive inside the release window.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WAIT   = 3'd2,
        ST_WSETUP = 3'd3,
        ST_WPULSE = 3'd4,
        ST_WHOLD  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic ce;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } ram_pins_t;

    localparam ram_pins_t PINS_PARKED = '{ce_n: 1'b1, ce: 1'b0, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    function automatic int unsigned cycles_for(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Grade-dependent limits in nanoseconds (slow = 1)
    function automatic int unsigned t_cycle_ns(input bit slow);
        return slow ? 70 : 55;
    endfunction

    function automatic int unsigned t_access_ns(input bit slow);
        return slow ? 70 : 55;
    endfunction

    function automatic int unsigned t_oe_valid_ns(input bit slow);
        return slow ? 40 : 30;
    endfunction

    function automatic int unsigned t_oe_release_ns(input bit slow);
        return slow ? 35 : 30;
    endfunction

    function automatic int unsigned t_ce_release_ns(input bit slow);
        return slow ? 40 : 35;
    endfunction

    function automatic ram_pins_t pins_for(input seq_state_e st);
        ram_pins_t p;
        p = PINS_PARKED;
        case (st)
            ST_READ: begin
                p.ce_n = 1'b0;
                p.ce   = 1'b1;
                p.oe_n = 1'b0;
            end
            ST_WSETUP, ST_WHOLD: begin
                p.ce_n  = 1'b0;
                p.ce    = 1'b1;
                p.dq_oe = 1'b1;
            end
            ST_WPULSE: begin
                p.ce_n  = 1'b0;
                p.ce    = 1'b1;
                p.we_n  = 1'b0;
                p.dq_oe = 1'b1;
            end
            default: p = PINS_PARKED;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_interval_counter.sv
module sram_interval_counter #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

    // Decrement saturates at zero rather than wrapping (R3/R5 interval lengths)
    a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == '0 && !$past(load)) |-> (cnt_q == '0));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned RD_CYC = 6,
    parameter int unsigned WE_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    input  logic [CNT_W-1:0]  phase_cnt,
    input  logic [CNT_W-1:0]  quiet_cnt,
    output seq_state_e        state_d,
    output logic              phase_load,
    output logic [CNT_W-1:0]  phase_val,
    output logic              phase_dec,
    output logic              quiet_load,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              ready;
    } fsm_regs_t;

    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    fsm_regs_t r_d, r_q;
    logic      bus_settling;

    // The RAM may still drive the bus while more than one quiet cycle remains
    assign bus_settling = (quiet_cnt > ONE);

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        phase_load = 1'b0;
        phase_val  = '0;
        phase_dec  = 1'b0;
        quiet_load = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    if (req_we) begin
                        r_d.st = bus_settling ? ST_WAIT : ST_WSETUP;
                    end else begin
                        r_d.st     = ST_READ;
                        phase_load = 1'b1;
                        phase_val  = RD_LAST;
                    end
                end
            end
            ST_READ: begin
                if (phase_cnt == '0) begin
                    r_d.st     = ST_IDLE;
                    r_d.rdata  = dq_in;
                    r_d.done   = 1'b1;
                    quiet_load = 1'b1;
                end else begin
                    phase_dec = 1'b1;
                end
            end
            ST_WAIT: begin
                if (!bus_settling) begin
                    r_d.st = ST_WSETUP;
                end
            end
            ST_WSETUP: begin
                r_d.st     = ST_WPULSE;
                phase_load = 1'b1;
                phase_val  = WE_LAST;
            end
            ST_WPULSE: begin
                if (phase_cnt == '0) begin
                    r_d.st = ST_WHOLD;
                end else begin
                    phase_dec = 1'b1;
                end
            end
            ST_WHOLD: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.ready = (r_d.st == ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
            r_q.rdata <= '0;
            r_q.done  <= 1'b0;
            r_q.ready <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_d = r_d.st;
    assign ready   = r_q.ready;
    assign done    = r_q.done;
    assign rdata   = r_q.rdata;
    assign addr_q  = r_q.addr;
    assign wdata_q = r_q.wdata;

    // R4/R7: completion is a single-cycle pulse
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: the captured request is frozen while the controller is busy
    a_r2_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !$past(ready)) |-> ($stable(addr_q) && $stable(wdata_q)));

endmodule

// File: rtl/sram_pin_stage.sv
module sram_pin_stage
    import sram_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state_d,
    output ram_pins_t  pins_q
);

    ram_pins_t pins_d;

    always_comb begin
        pins_d = pins_for(state_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pins_q <= PINS_PARKED;
        end else begin
            pins_q <= pins_d;
        end
    end

    // R5: a write strobe never coincides with the RAM output enabled
    a_r5_we_excludes_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_q.we_n |-> (pins_q.oe_n && pins_q.dq_oe && !pins_q.ce_n));

    // R3: while the RAM output is enabled the controller does not drive
    a_r3_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_q.oe_n |-> (!pins_q.dq_oe && pins_q.we_n));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 17,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter bit          SLOW_GRADE    = 1'b0,
    parameter int unsigned WE_PULSE_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_ce_n,
    output logic              ram_ce,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in
);

    localparam int unsigned RD_CYC = max2(max2(cycles_for(t_cycle_ns(SLOW_GRADE), CLK_PERIOD_NS),
                                              cycles_for(t_access_ns(SLOW_GRADE), CLK_PERIOD_NS)),
                                         cycles_for(t_oe_valid_ns(SLOW_GRADE), CLK_PERIOD_NS));
    localparam int unsigned TURN_CYC = max2(cycles_for(t_oe_release_ns(SLOW_GRADE), CLK_PERIOD_NS),
                                           cycles_for(t_ce_release_ns(SLOW_GRADE), CLK_PERIOD_NS));
    localparam int unsigned WE_CYC  = (WE_PULSE_CYC < 1) ? 1 : WE_PULSE_CYC;
    localparam int unsigned MAX_CNT = max2(max2(RD_CYC, WE_CYC), TURN_CYC);
    localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
    localparam int unsigned GAP_W   = $clog2(TURN_CYC + 2);

    seq_state_e        state_d;
    ram_pins_t         pins_q;
    logic              phase_load, phase_dec, quiet_load;
    logic [CNT_W-1:0]  phase_val, phase_cnt, quiet_cnt;

    sram_seq_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .WE_CYC (WE_CYC)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_we     (req_we),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .dq_in      (dq_in),
        .phase_cnt  (phase_cnt),
        .quiet_cnt  (quiet_cnt),
        .state_d    (state_d),
        .phase_load (phase_load),
        .phase_val  (phase_val),
        .phase_dec  (phase_dec),
        .quiet_load (quiet_load),
        .ready      (ready),
        .done       (done),
        .rdata      (rdata),
        .addr_q     (ram_addr),
        .wdata_q    (dq_out)
    );

    // Phase timer: read interval and write-strobe width
    sram_interval_counter #(.CNT_W(CNT_W)) i_phase_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .dec      (phase_dec),
        .count    (phase_cnt)
    );

    // Quiet timer: bus release window after a read, free-running down to zero
    sram_interval_counter #(.CNT_W(CNT_W)) i_quiet_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (quiet_load),
        .load_val (CNT_W'(TURN_CYC)),
        .dec      (1'b1),
        .count    (quiet_cnt)
    );

    sram_pin_stage i_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .pins_q  (pins_q)
    );

    assign ram_ce_n = pins_q.ce_n;
    assign ram_ce   = pins_q.ce;
    assign ram_we_n = pins_q.we_n;
    assign ram_oe_n = pins_q.oe_n;
    assign dq_oe    = pins_q.dq_oe;

    // Independent gap monitor: cycles since the RAM output was last enabled
    logic [GAP_W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (!ram_oe_n) begin
            gap_d = '0;
        end else if (gap_q < GAP_W'(TURN_CYC)) begin
            gap_d = gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= GAP_W'(TURN_CYC);
        end else begin
            gap_q <= gap_d;
        end
    end

    a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (gap_q >= GAP_W'(TURN_CYC)));

    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_ce_n && $past(!ram_ce_n)) |-> $stable(ram_addr));

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_ce_n |-> !ready);

    a_r1_enables_agree: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce_n |-> (!ram_ce && ram_we_n && ram_oe_n && !dq_oe));

endmodule

// File: tb/test_sram_ctrl.sv
module test_sram_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int T_RC = 55, T_AA = 55, T_OE = 30, T_OHZ = 30, T_CHZ = 35;
    localparam int C_RC = (T_RC + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_AA = (T_AA + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_OE = (T_OE + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_OHZ = (T_OHZ + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int C_CHZ = (T_CHZ + CLK_PERIOD - 1) / CLK_PERIOD;
    localparam int RD = (C_RC > C_AA ? (C_RC > C_OE ? C_RC : C_OE) : (C_AA > C_OE ? C_AA : C_OE));
    localparam int TURN = (C_OHZ > C_CHZ) ? C_OHZ : C_CHZ;
    localparam int WE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, done;
    logic [7:0]  rdata;
    logic [16:0] ram_addr;
    logic        ram_ce_n, ram_ce, ram_we_n, ram_oe_n, dq_oe;
    logic [7:0]  dq_out;
    logic [7:0]  dq_in = 8'h5A;

    sram_ctrl i_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .ready(ready), .done(done), .rdata(rdata),
        .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_ce(ram_ce), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // kind: 0 idle, 1 read, 2 write wait, 3 write active, 4 read done, 5 write done
    typedef struct {
        int          kind;
        bit          sel;
        bit          we_n;
        bit          oe_n;
        bit          dq_oe;
        logic [16:0] addr;
        logic [7:0]  dout;
        bit          ready;
        bit          done;
        logic [7:0]  rdata;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] ram_mem[int];
    logic [7:0] ref_mem[int];
    int rel_edge = -1000;
    int last_rd_cyc = -1000;
    int rd_age = 0;
    bit prev_we_n = 1'b1;
    int accepted_n = 0;
    int done_n = 0;

    function automatic logic [7:0] fill(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C ^ {7'b0, a[16]};
    endfunction

    function automatic logic [7:0] ram_get(input logic [16:0] a);
        return ram_mem.exists(int'(a)) ? ram_mem[int'(a)] : fill(a);
    endfunction

    function automatic logic [7:0] ref_get(input logic [16:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : fill(a);
    endfunction

    function automatic exp_t idle_exp();
        exp_t e;
        e.kind = 0; e.sel = 0; e.we_n = 1; e.oe_n = 1; e.dq_oe = 0;
        e.addr = '0; e.dout = '0; e.ready = 1; e.done = 0; e.rdata = '0;
        return e;
    endfunction

    function automatic string tag_of(input int k);
        case (k)
            0: return "R1";
            1: return "R3";
            2: return "R6";
            3: return "R5";
            4: return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic push_access(input int a, input bit w, input logic [16:0] ad, input logic [7:0] wd);
        exp_t e;
        accepted_n++;
        if (!w) begin
            for (int i = 0; i < RD; i++) begin
                e = idle_exp(); e.kind = 1; e.sel = 1; e.oe_n = 0; e.addr = ad; e.ready = 0;
                exp_q.push_back(e);
            end
            e = idle_exp(); e.kind = 4; e.done = 1; e.rdata = ref_get(ad);
            exp_q.push_back(e);
            rel_edge = a + RD;
        end else begin
            int start;
            start = (a > rel_edge + TURN) ? a : rel_edge + TURN;
            for (int i = a; i < start; i++) begin
                e = idle_exp(); e.kind = 2; e.ready = 0;
                exp_q.push_back(e);
            end
            for (int i = 0; i < WE + 2; i++) begin
                e = idle_exp(); e.kind = 3; e.sel = 1; e.dq_oe = 1; e.addr = ad; e.dout = wd;
                e.ready = 0; e.we_n = (i == 0 || i == WE + 1);
                exp_q.push_back(e);
            end
            e = idle_exp(); e.kind = 5; e.done = 1;
            exp_q.push_back(e);
            ref_mem[int'(ad)] = wd;
        end
    endtask

    // Reference model and RAM model, evaluated away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            exp_t e;
            bit sel;
            string t;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : idle_exp();
            t = tag_of(e.kind);
            chk({ram_ce_n, ram_ce, ram_we_n, ram_oe_n, dq_oe} == {!e.sel, e.sel, e.we_n, e.oe_n, e.dq_oe},
                t, "pins ce_n/ce/we_n/oe_n/dq_oe",
                {27'b0, ram_ce_n, ram_ce, ram_we_n, ram_oe_n, dq_oe},
                {27'b0, !e.sel, e.sel, e.we_n, e.oe_n, e.dq_oe});
            chk({ready, done} == {e.ready, e.done}, (e.kind == 4) ? "R4" : t, "ready/done",
                {30'b0, ready, done}, {30'b0, e.ready, e.done});
            if (e.sel) chk(ram_addr == e.addr, "R8", "ram_addr", 32'(ram_addr), 32'(e.addr));
            if (e.dq_oe) chk(dq_out == e.dout, "R5", "dq_out", 32'(dq_out), 32'(e.dout));
            if (e.kind == 4) chk(rdata == e.rdata, "R4", "rdata", 32'(rdata), 32'(e.rdata));
            if (done) done_n++;

            // R6: no drive while the RAM may still hold the bus
            if (dq_oe) chk(cyc > last_rd_cyc + TURN, "R6", "drive inside release window",
                           32'(cyc - last_rd_cyc), 32'(TURN + 1));

            // RAM behaviour
            sel = !ram_ce_n && ram_ce;
            if (sel && ram_we_n && !ram_oe_n) begin
                rd_age++;
                last_rd_cyc = cyc;
                dq_in <= (rd_age >= RD) ? ram_get(ram_addr) : ~ram_get(ram_addr);
            end else begin
                rd_age = 0;
                dq_in <= 8'h5A;
            end
            if (sel && !prev_we_n && ram_we_n) ram_mem[int'(ram_addr)] = dq_out;
            prev_we_n = ram_we_n;

            // predict acceptance at the coming edge (R2)
            if (req && ready) push_access(cyc + 1, req_we, req_addr, req_wdata);
        end
    end

    task automatic access(input bit w, input logic [16:0] a, input logic [7:0] d);
        req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        while (!ready) @(negedge clk);
        @(posedge clk); #1;
        req = 1'b0;
        req_addr = ~a;
        req_wdata = ~d;
    endtask

    task automatic drain();
        do @(negedge clk); while (exp_q.size() > 0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk({ram_ce_n, ram_ce, ram_we_n, ram_oe_n, dq_oe, ready, done} == 7'b1011010,
            "R1", "reset pins", {25'b0, ram_ce_n, ram_ce, ram_we_n, ram_oe_n, dq_oe, ready, done},
            32'b1011010);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;

        // R5 then R4: write then read back
        access(1'b1, 17'h00123, 8'hC3);
        drain();
        access(1'b0, 17'h00123, 8'h00);
        drain();
        // R4: unwritten location, then address extremes and data extremes
        access(1'b0, 17'h0ABCD, 8'h00);
        access(1'b1, 17'h00000, 8'hFF);
        access(1'b1, 17'h1FFFF, 8'h00);
        access(1'b0, 17'h00000, 8'h00);
        // R6: read immediately followed by write
        access(1'b1, 17'h1FFFF, 8'h96);
        access(1'b0, 17'h1FFFF, 8'h00);
        drain();
        // R7: write after long idle, no wait
        repeat (8) @(posedge clk); #1;
        access(1'b1, 17'h05555, 8'h5A);
        access(1'b0, 17'h05555, 8'h00);
        drain();

        // R2: request held high while inputs change every cycle
        begin
            logic [31:0] lcg;
            lcg = 32'h1234_5678;
            req = 1'b1;
            for (int i = 0; i < 120; i++) begin
                lcg = lcg * 32'd1664525 + 32'd1013904223;
                req_we = lcg[31];
                req_addr = {lcg[20], 8'h00, lcg[27:24], lcg[13:10]};
                req_wdata = lcg[23:16];
                @(posedge clk); #1;
            end
            req = 1'b0;
        end
        drain();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(accepted_n == done_n, "R2", "accepted vs done pulses", 32'(done_n), 32'(accepted_n));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule